// File: doc/BRIEF.md
# SMBus Register-File Slave

This block is a two-wire bus slave that exposes a small bank of 8-bit control registers to a host. It watches SCL and SDA lines that have already been brought into the system clock domain, and it pulls SDA low through a registered open-drain enable whenever it acknowledges or sends a zero bit. It answers to the 7-bit address 0x69 (0xD2 with the write bit) and supports four transfer types. The command byte selects the type. With bit 7 set, the transfer is indexed and moves one byte at the offset held in bits 6:0. With bit 7 clear, the transfer is counted and always starts at register index 4.

Registers 4 through 14 are implemented. Index 5 mirrors the strap inputs and cannot be written. Index 8 holds a fixed signature. Every other implemented index is a plain read/write byte. The block sends each accepted write out as a one-cycle strobe that carries the index and the data, and it presents all register contents in parallel on one flat output bus.

Top module: `smbus_regfile`

## Requirements
- R1: Only address byte 0xD2/0xD3 (7-bit 0x69) is acknowledged. For any other address, SDA stays released for the rest of that transaction and no register changes.
- R2: Byte write: after command 1xxxxxxx, one data byte is written to offset bits 6:0. Any further data bytes in the same transaction are acknowledged and discarded.
- R3: Byte read: after the write address, a 1xxxxxxx command, a repeated start and the read address 0xD3, the slave returns the register at the offset, most significant bit first.
- R4: Block write: after command 0x00 and a count byte N, data bytes go to indices 4, 5, 6 and upward in order. Only the first N data bytes are written, and bytes beyond N are acknowledged and discarded.
- R5: Block read: after command 0x00, a repeated start and 0xD3, the slave first returns the count 0x0B (the 11 implemented registers). It then returns indices 4, 5 and upward until the master NACKs.
- R6: Index 5 reads as {2'b00, strap_i}. Index 8 reads as 0x80. Writes to either index are acknowledged, produce no strobe and leave the value unchanged.
- R7: Offsets outside 4..14 read as 0x00. Writes to them are acknowledged and have no effect.
- R8: In a transaction addressed to the slave, every byte the master sends is acknowledged: SDA is low while SCL is high on the ninth clock.
- R9: A stop condition in the middle of a byte abandons the transfer. Nothing is written, and SDA is released.
- R10: A start condition in the middle of a byte discards the partial byte and begins a new address phase.
- R11: After reset, SDA is released, no strobe is active, read/write registers hold 0x00 and the signature holds 0x80.
- R12: wr_stb_o pulses for exactly one cycle, two clocks after the SCL falling edge of the eighth data bit. The register content changes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL line |
| sda_i | input | 1 | Synchronized SDA line |
| strap_i | input | 6 | Latched strap levels mirrored into index 5 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_stb_o | output | 1 | One-cycle write strobe for a writable register |
| wr_idx_o | output | 7 | Register index of the strobed write |
| wr_data_o | output | 8 | Data of the strobed write |
| regs_o | output | 88 | Contents of indices 4..14, index 4 in the low byte |

## Verification
SDA responses (acknowledge and read bits) change one clock after the SCL falling edge that precedes them. The bench holds each SCL phase for four clocks and samples SDA two clocks into the high phase, well after any change has settled. The write strobe and the new register value arrive two clocks after the eighth data bit's SCL fall. The bench records the clock count at that fall and the clock count at which a falling-edge monitor first sees the strobe, then compares the difference with 2. Contents and the absence of writes are checked by reading back through the bus or from the parallel register output, only after a stop condition has completed.

// File: rtl/smb_rf_pkg.sv
package smb_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WCNT,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } smb_state_t;

  typedef enum logic [1:0] {
    RK_RW,
    RK_STRAP,
    RK_SIG
  } reg_kind_t;

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL is held high marks the frame boundaries.
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_rf_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         BASE_IDX = 4,
  parameter int         NREGS    = 11,
  parameter int         IDX_W    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sda_i,
  input  logic [7:0]       rd_data_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             sda_oe_o,
  output logic             wreq_o,
  output logic [IDX_W-1:0] widx_o,
  output logic [7:0]       wdata_o
);

  localparam logic [IDX_W-1:0] BASE_P  = IDX_W'(BASE_IDX);
  localparam logic [7:0]       COUNT_P = 8'(NREGS);

  smb_state_t       st;
  logic [3:0]       bcnt;    // SCL rising edges seen in the 9-clock frame
  logic [7:0]       sh;
  logic [7:0]       tx;
  logic             blk;
  logic             rd_first;
  logic [IDX_W-1:0] ptr;
  logic [7:0]       left;    // data bytes still allowed to land
  logic [7:0]       nxt;

  assign rd_idx_o = ptr;
  assign nxt      = rd_first ? COUNT_P : rd_data_i;

  always_ff @(posedge clk) begin
    wreq_o <= 1'b0;
    if (rst) begin
      st       <= ST_IDLE;
      bcnt     <= '0;
      sh       <= '0;
      tx       <= '0;
      sda_oe_o <= 1'b0;
      blk      <= 1'b0;
      rd_first <= 1'b0;
      ptr      <= '0;
      left     <= '0;
      widx_o   <= '0;
      wdata_o  <= '0;
    end else if (stop_i) begin
      st       <= ST_IDLE;
      bcnt     <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      st       <= ST_ADDR;
      bcnt     <= '0;
      sda_oe_o <= 1'b0;
    end else if (st != ST_IDLE && st != ST_SKIP) begin
      if (rise_i) begin
        if (bcnt < 4'd8) begin
          sh   <= {sh[6:0], sda_i};
          bcnt <= bcnt + 4'd1;
        end else if (bcnt == 4'd8) begin
          bcnt <= 4'd9;
          if (st == ST_RDAT && sda_i) st <= ST_SKIP;   // master NACK ends the read
        end
      end else if (fall_i) begin
        if (bcnt == 4'd8) begin
          unique case (st)
            ST_ADDR: begin
              if (sh[7:1] == ADDR7) begin
                sda_oe_o <= 1'b1;
                if (sh[0]) begin
                  st       <= ST_RDAT;
                  rd_first <= blk;
                end else begin
                  st <= ST_CMD;
                end
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_CMD: begin
              sda_oe_o <= 1'b1;
              blk      <= ~sh[7];
              ptr      <= sh[7] ? sh[IDX_W-1:0] : BASE_P;
              left     <= sh[7] ? 8'd1 : 8'd0;
              st       <= sh[7] ? ST_WDAT : ST_WCNT;
            end
            ST_WCNT: begin
              sda_oe_o <= 1'b1;
              left     <= sh;
              st       <= ST_WDAT;
            end
            ST_WDAT: begin
              sda_oe_o <= 1'b1;
              if (left != 8'd0) begin
                wreq_o  <= 1'b1;
                widx_o  <= ptr;
                wdata_o <= sh;
                ptr     <= ptr + 1'b1;
                left    <= left - 8'd1;
              end
            end
            default: sda_oe_o <= 1'b0;   // read byte done: master owns the ack slot
          endcase
        end else if (bcnt == 4'd9) begin
          bcnt <= '0;
          if (st == ST_RDAT) begin
            tx       <= nxt;
            sda_oe_o <= ~nxt[7];
            rd_first <= 1'b0;
            if (!rd_first) ptr <= ptr + 1'b1;
          end else begin
            sda_oe_o <= 1'b0;
          end
        end else if (st == ST_RDAT) begin
          tx       <= {tx[6:0], 1'b0};
          sda_oe_o <= ~tx[6];
        end
      end
    end
  end

  p_foreign_noack_r1: assert property (@(posedge clk) disable iff (rst)
    (fall_i && bcnt == 4'd8 && st == ST_ADDR && sh[7:1] != ADDR7) |=> !sda_oe_o)
    else $error("acknowledged a foreign address");

  p_oe_window_r8: assert property (@(posedge clk) disable iff (rst)
    sda_oe_o |-> (st == ST_RDAT || bcnt == 4'd8 || bcnt == 4'd9))
    else $error("SDA driven outside an ack slot or read byte");

  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!sda_oe_o && st == ST_IDLE))
    else $error("stop did not return to idle");

  p_wreq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    wreq_o |=> !wreq_o)
    else $error("write request longer than one cycle");

  p_wreq_after_fall_r12: assert property (@(posedge clk) disable iff (rst)
    wreq_o |-> $past(fall_i))
    else $error("write request not aligned to an SCL fall");

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_rf_pkg::*;
#(
  parameter int         BASE_IDX  = 4,
  parameter int         NREGS     = 11,
  parameter int         STRAP_IDX = 5,
  parameter int         SIG_IDX   = 8,
  parameter logic [7:0] SIG_VAL   = 8'h80,
  parameter logic [7:0] RW_RST    = 8'h00,
  parameter int         STRAP_W   = 6,
  parameter int         IDX_W     = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wreq_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [7:0]         wdata_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic               wr_stb_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [7:0]         wr_data_o,
  output logic [NREGS*8-1:0] regs_o
);

  function automatic reg_kind_t kind_of(input int idx);
    if (idx == STRAP_IDX) return RK_STRAP;
    if (idx == SIG_IDX)   return RK_SIG;
    return RK_RW;
  endfunction

  logic [NREGS-1:0] hit;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE_IDX + g);
    logic [7:0] q;
    assign regs_o[g*8 +: 8] = q;

    if (kind_of(BASE_IDX + g) == RK_SIG) begin : g_sig
      assign q      = SIG_VAL;
      assign hit[g] = 1'b0;
    end else if (kind_of(BASE_IDX + g) == RK_STRAP) begin : g_strap
      assign hit[g] = 1'b0;
      always_ff @(posedge clk) begin
        if (rst) q <= 8'h00;
        else     q <= 8'(strap_i);
      end
    end else begin : g_rw
      assign hit[g] = wreq_i && (widx_i == MY_IDX);
      always_ff @(posedge clk) begin
        if (rst)         q <= RW_RST;
        else if (hit[g]) q <= wdata_i;
      end

      p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o && wr_idx_o == MY_IDX) |-> (q == wr_data_o))
        else $error("strobed write not visible in register");
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int g = 0; g < NREGS; g++) begin
      if (rd_idx_i == IDX_W'(BASE_IDX + g)) rd_data_o = regs_o[g*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= |hit;
      if (wreq_i) begin
        wr_idx_o  <= widx_i;
        wr_data_o <= wdata_i;
      end
    end
  end

  p_ro_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> (wr_idx_o != IDX_W'(STRAP_IDX) && wr_idx_o != IDX_W'(SIG_IDX)))
    else $error("strobe issued for a read-only index");

  p_stb_follows_req_r12: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> $past(wreq_i))
    else $error("strobe without a request one cycle earlier");

endmodule

// File: rtl/smbus_regfile.sv
module smbus_regfile #(
  parameter logic [6:0] ADDR7     = 7'h69,
  parameter int         BASE_IDX  = 4,
  parameter int         NREGS     = 11,
  parameter int         STRAP_IDX = 5,
  parameter int         SIG_IDX   = 8,
  parameter logic [7:0] SIG_VAL   = 8'h80,
  parameter int         STRAP_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               wr_stb_o,
  output logic [6:0]         wr_idx_o,
  output logic [7:0]         wr_data_o,
  output logic [NREGS*8-1:0] regs_o
);

  localparam int IDX_W = 7;

  logic             ev_start, ev_stop, ev_rise, ev_fall;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;
  logic             wreq;
  logic [IDX_W-1:0] widx;
  logic [7:0]       wdata;

  smb_line_events u_events (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (ev_start),
    .stop_o  (ev_stop),
    .rise_o  (ev_rise),
    .fall_o  (ev_fall)
  );

  smb_xfer_fsm #(
    .ADDR7    (ADDR7),
    .BASE_IDX (BASE_IDX),
    .NREGS    (NREGS),
    .IDX_W    (IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (ev_start),
    .stop_i    (ev_stop),
    .rise_i    (ev_rise),
    .fall_i    (ev_fall),
    .sda_i     (sda_i),
    .rd_data_i (rd_data),
    .rd_idx_o  (rd_idx),
    .sda_oe_o  (sda_oe_o),
    .wreq_o    (wreq),
    .widx_o    (widx),
    .wdata_o   (wdata)
  );

  smb_reg_bank #(
    .BASE_IDX  (BASE_IDX),
    .NREGS     (NREGS),
    .STRAP_IDX (STRAP_IDX),
    .SIG_IDX   (SIG_IDX),
    .SIG_VAL   (SIG_VAL),
    .RW_RST    (8'h00),
    .STRAP_W   (STRAP_W),
    .IDX_W     (IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wreq_i    (wreq),
    .widx_i    (widx),
    .wdata_i   (wdata),
    .strap_i   (strap_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .regs_o    (regs_o)
  );

endmodule

// File: tb/smbus_regfile_test.sv
`timescale 1ns/1ps
module smbus_regfile_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [5:0]  strap = 6'h2B;
  logic        sda_oe;
  logic        wr_stb;
  logic [6:0]  wr_idx;
  logic [7:0]  wr_data;
  logic [87:0] regs;
  wire         sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int fall_cyc = 0;
  int stb_n = 0;
  int stb_cyc = 0;
  logic [6:0] stb_idx;
  logic [7:0] stb_dat;
  logic [7:0] exp_m [0:127];

  smbus_regfile uut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_oe_o  (sda_oe),
    .wr_stb_o  (wr_stb),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .regs_o    (regs)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_n   = stb_n + 1;
      stb_idx = wr_idx;
      stb_dat = wr_data;
      stb_cyc = cyc;
    end
  end

  function automatic logic [7:0] slot(input int idx);
    return regs[(idx-4)*8 +: 8];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(4);
    scl_m = 1'b1; hold(4);
    sda_m = 1'b0; hold(4);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(4);
    scl_m = 1'b1; hold(4);
    sda_m = 1'b1; hold(4);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b;    hold(4);
    scl_m = 1'b1; hold(2);
    s = sda_line; hold(2);
    scl_m = 1'b0;
    fall_cyc = cyc;
    hold(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output int last_fall);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    last_fall = fall_cyc;
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(nack, s);
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d, input string tag);
    logic a0, a1, a2;
    int lf;
    bus_start();
    send_byte(8'hD2, a0, lf);
    send_byte({1'b1, off}, a1, lf);
    send_byte(d, a2, lf);
    bus_stop();
    chk("R8", {tag, " acks"}, {a0, a1, a2}, 3'b111);
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
    logic a;
    int lf;
    bus_start();
    send_byte(8'hD2, a, lf);
    send_byte({1'b1, off}, a, lf);
    bus_start();
    send_byte(8'hD3, a, lf);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11", "sda released", sda_oe, 1'b0);
    chk("R11", "no strobe", wr_stb, 1'b0);
    chk("R11", "signature", slot(8), 8'h80);
    chk("R11", "rw idx4", slot(4), 8'h00);
    chk("R11", "rw idx14", slot(14), 8'h00);
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2, a3;
    int lf, data_fall, n0;
    n0 = stb_n;
    bus_start();
    send_byte(8'hD2, a0, lf);
    send_byte(8'h87, a1, lf);
    send_byte(8'hA5, a2, data_fall);
    send_byte(8'h3C, a3, lf);
    bus_stop();
    exp_m[7] = 8'hA5;
    chk("R8", "byte write acks", {a0, a1, a2, a3}, 4'hF);
    chk("R2", "one strobe", stb_n - n0, 1);
    chk("R2", "strobe index", stb_idx, 7'd7);
    chk("R2", "strobe data", stb_dat, 8'hA5);
    chk("R12", "strobe latency", stb_cyc - data_fall, 2);
    chk("R2", "idx7 content", slot(7), 8'hA5);
    chk("R2", "extra byte discarded", slot(8), 8'h80);
  endtask

  task automatic t_byte_read();
    logic [7:0] d;
    byte_read(7'd7, d);
    chk("R3", "read idx7", d, 8'hA5);
    byte_read(7'd4, d);
    chk("R3", "read idx4", d, 8'h00);
  endtask

  task automatic t_foreign();
    logic a0, a1, a2;
    int lf, n0;
    logic [7:0] d;
    n0 = stb_n;
    bus_start();
    send_byte(8'hD4, a0, lf);
    send_byte(8'h87, a1, lf);
    send_byte(8'h11, a2, lf);
    bus_stop();
    chk("R1", "no ack foreign", {a0, a1, a2}, 3'b000);
    chk("R1", "no strobe foreign", stb_n - n0, 0);
    byte_read(7'd7, d);
    chk("R1", "idx7 untouched", d, 8'hA5);
  endtask

  task automatic t_block_write();
    logic a [0:6];
    int lf, n0;
    logic [7:0] seq [0:6];
    seq[0] = 8'hD2; seq[1] = 8'h00; seq[2] = 8'h03;
    seq[3] = 8'h11; seq[4] = 8'h22; seq[5] = 8'h33; seq[6] = 8'h44;
    n0 = stb_n;
    bus_start();
    for (int i = 0; i < 7; i++) send_byte(seq[i], a[i], lf);
    bus_stop();
    exp_m[4] = 8'h11;
    exp_m[6] = 8'h33;
    for (int i = 0; i < 7; i++) chk("R8", "block write ack", a[i], 1'b1);
    chk("R4", "two strobes", stb_n - n0, 2);
    chk("R4", "idx4", slot(4), 8'h11);
    chk("R6", "strap idx5 kept", slot(5), {2'b00, strap});
    chk("R4", "idx6", slot(6), 8'h33);
    chk("R4", "beyond count", slot(7), 8'hA5);
  endtask

  task automatic t_block_read();
    logic a;
    int lf;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a, lf);
    send_byte(8'h00, a, lf);
    bus_start();
    send_byte(8'hD3, a, lf);
    recv_byte(1'b0, d);
    chk("R5", "count byte", d, 8'h0B);
    for (int i = 0; i < 11; i++) begin
      recv_byte(i == 10, d);
      chk("R5", $sformatf("block idx %0d", 4 + i), d, exp_m[4+i]);
    end
    bus_stop();
    chk("R5", "sda released", sda_oe, 1'b0);
  endtask

  task automatic t_ro_write();
    logic [7:0] d;
    int n0;
    n0 = stb_n;
    byte_write(7'd8, 8'h00, "sig");
    byte_read(7'd8, d);
    chk("R6", "signature kept", d, 8'h80);
    byte_write(7'd5, 8'hFF, "strap");
    byte_read(7'd5, d);
    chk("R6", "strap mirror", d, {2'b00, strap});
    chk("R6", "no strobe read-only", stb_n - n0, 0);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    int n0;
    n0 = stb_n;
    byte_write(7'd2, 8'h55, "low");
    byte_write(7'd15, 8'h66, "high");
    chk("R7", "no strobe", stb_n - n0, 0);
    byte_read(7'd2, d);
    chk("R7", "read idx2", d, 8'h00);
    byte_read(7'd15, d);
    chk("R7", "read idx15", d, 8'h00);
    byte_read(7'h40, d);
    chk("R7", "read idx64", d, 8'h00);
  endtask

  task automatic t_stop_mid();
    logic a, s;
    int lf, n0;
    logic [7:0] d;
    n0 = stb_n;
    bus_start();
    send_byte(8'hD2, a, lf);
    send_byte(8'h89, a, lf);
    for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
    bus_stop();
    chk("R9", "sda released", sda_oe, 1'b0);
    chk("R9", "no strobe", stb_n - n0, 0);
    byte_read(7'd9, d);
    chk("R9", "idx9 unchanged", d, 8'h00);
  endtask

  task automatic t_start_mid();
    logic a0, a1, a2, s;
    int lf;
    bus_start();
    send_byte(8'hD2, a0, lf);
    send_byte(8'h8A, a0, lf);
    for (int i = 0; i < 5; i++) clock_bit(1'b1, s);
    bus_start();
    send_byte(8'hD2, a0, lf);
    send_byte(8'h8B, a1, lf);
    send_byte(8'h5A, a2, lf);
    bus_stop();
    chk("R10", "new transaction acks", {a0, a1, a2}, 3'b111);
    chk("R10", "idx10 untouched", slot(10), 8'h00);
    chk("R10", "idx11 written", slot(11), 8'h5A);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) exp_m[i] = 8'h00;
    exp_m[5] = {2'b00, strap};
    exp_m[8] = 8'h80;
    hold(5);
    rst = 1'b0;
    hold(4);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_foreign();
    t_block_write();
    t_block_read();
    t_ro_write();
    t_unimpl();
    t_stop_mid();
    t_start_mid();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule